// File: doc/BRIEF.md
# Pipelined Minifloat Adder with Round-to-Nearest-Even

This block adds two small binary floating-point words with a hidden leading significand bit and returns their correctly rounded sum. Subtraction is expressed through the operand signs: when the signs differ the block subtracts magnitudes. Each operation goes through a fixed two-stage pipeline. The first stage unpacks the operands, orders them by magnitude and aligns the smaller one. The second stage combines the significands, normalises the result, rounds it and packs it.

The default word is nine bits wide. It holds one sign bit, a five-bit biased exponent and a three-bit stored fraction, which gives four bits of significand precision. Because the biased exponent sits above the fraction, the magnitudes can be ordered by a plain unsigned compare of the packed bits below the sign. A producer presents an operand pair with an input strobe. The packed result appears with an output strobe a fixed number of cycles later. A new pair may be accepted on every cycle.

Top module: `minifloat_adder`

## Requirements
- R1: `outValid` is high in exactly the cycles that follow, by two rising clock edges, the edges at which `inValid` was sampled high. Back-to-back and gapped strobes are both supported, and each result is paired with its own inputs.
- R2: While `rstN` is low and until the first result is produced, `outValid` and `outSum` are zero.
- R3: The word layout, from most to least significant bit, is sign (bit 8, 1 means negative), exponent field (bits 7:3, bias 15) and fraction (bits 2:0). A value is (1.fraction) × 2^(field−15). An exponent field of 0 denotes zero whatever the fraction holds. Inputs never carry the all-ones field 31.
- R4: For any two operands within the range of R3, `outSum` equals the exact sum rounded to four significand bits under round-to-nearest. This covers effective addition with carry-out and effective subtraction with any amount of cancellation.
- R5: When the operand signs differ, the sign of a non-zero result is the sign of the operand with the larger magnitude, whichever port carries that operand.
- R6: When the discarded part of the exact sum is exactly half a unit in the last place, the result rounds to the candidate whose least significant fraction bit is 0.
- R7: Bits of the smaller operand shifted below the rounding position are not lost. Any non-zero remnant tips a result that would otherwise be a tie, and a large exponent gap in a subtraction still yields the correctly rounded value.
- R8: A result that is exactly zero is the all-zero word (positive sign), including when both operands are zero.
- R9: If the rounded result's exponent field would exceed 30, the result is the largest finite magnitude (field 30, fraction 111) carrying the result's sign.
- R10: If the rounded result's exponent field would fall below 1, the result is the all-zero word.
- R11: If one operand is zero, the result is the other operand unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Operand pair on `opA`/`opB` is valid this cycle |
| opA | input | 9 | First packed operand |
| opB | input | 9 | Second packed operand |
| outValid | output | 1 | `outSum` holds a result this cycle |
| outSum | output | 9 | Packed rounded sum |

## Verification
The hardest situations to reach from the ports are rounding decisions that hinge on a single remnant bit: an exact tie, a tie broken only by sticky bits, and a subtraction across a wide exponent gap that borrows from the sticky position and then renormalises back up through a rounding carry. Directed operand pairs are built from chosen exponent gaps so that guard, round and sticky take each meaningful pattern. Random pairs then have their exponents drawn within a few steps of each other, which forces heavy cancellation. All of these are compared against an exact integer model of the sum.

// File: rtl/mfa_pkg.sv
package mfa_pkg;
  typedef struct packed {
    logic loadAlign;
    logic loadResult;
  } stageStrobe_t;
endpackage

// File: rtl/mfa_align.sv
module mfa_align #(
  parameter int W = 7,
  parameter int SH_W = 5
) (
  input  logic [W-1:0]    value,
  input  logic [SH_W-1:0] amt,
  output logic [W-1:0]    aligned
);
  logic [W-1:0] shifted;
  logic lost;

  always_comb begin
    lost = 1'b0;
    for (int i = 0; i < W; i++) begin
      if (i < int'(amt)) lost = lost | value[i];
    end
    shifted = value >> amt;
    aligned = {shifted[W-1:1], shifted[0] | lost};
  end
endmodule

// File: rtl/mfa_ctrl.sv
module mfa_ctrl
  import mfa_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  output stageStrobe_t strobe,
  output logic         outValid
);
  logic alignValid;
  logic resultValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      alignValid  <= 1'b0;
      resultValid <= 1'b0;
    end else begin
      alignValid  <= inValid;
      resultValid <= alignValid;
    end
  end

  always_comb begin
    strobe.loadAlign  = inValid;
    strobe.loadResult = alignValid;
  end

  assign outValid = resultValid;
endmodule

// File: rtl/mfa_datapath.sv
module mfa_datapath
  import mfa_pkg::*;
#(
  parameter int EXP_W = 5,
  parameter int FRAC_W = 3
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  stageStrobe_t            strobe,
  input  logic [EXP_W+FRAC_W:0]   opA,
  input  logic [EXP_W+FRAC_W:0]   opB,
  output logic [EXP_W+FRAC_W:0]   sumOut
);
  localparam int WORD_W  = 1 + EXP_W + FRAC_W;
  localparam int SIG_W   = FRAC_W + 1;
  localparam int EXT_W   = SIG_W + 3;
  localparam int LZ_W    = $clog2(EXT_W + 1);
  localparam int EI_W    = EXP_W + 2;
  localparam int EXP_MAX = (1 << EXP_W) - 2;

  // ---------------- stage 1: order, unpack, align ----------------
  logic [WORD_W-2:0] magA, magB;
  logic              aBigger;
  logic [WORD_W-1:0] bigOp, smallOp;
  logic [EXP_W-1:0]  bigExp, smallExp, shiftAmt;
  logic [SIG_W-1:0]  bigSig, smallSig;
  logic [EXT_W-1:0]  bigExt, smallExt, smallAligned;

  always_comb begin
    magA     = opA[WORD_W-2:0];
    magB     = opB[WORD_W-2:0];
    aBigger  = magA >= magB;
    bigOp    = aBigger ? opA : opB;
    smallOp  = aBigger ? opB : opA;
    bigExp   = bigOp[WORD_W-2:FRAC_W];
    smallExp = smallOp[WORD_W-2:FRAC_W];
    bigSig   = (bigExp == '0) ? '0 : {1'b1, bigOp[FRAC_W-1:0]};
    smallSig = (smallExp == '0) ? '0 : {1'b1, smallOp[FRAC_W-1:0]};
    shiftAmt = bigExp - smallExp;
    bigExt   = {bigSig, 3'b000};
    smallExt = {smallSig, 3'b000};
  end

  mfa_align #(.W(EXT_W), .SH_W(EXP_W)) uAlign (
    .value  (smallExt),
    .amt    (shiftAmt),
    .aligned(smallAligned)
  );

  logic             s1Sign, s1Sub;
  logic [EXP_W-1:0] s1Exp;
  logic [EXT_W-1:0] s1Big, s1Small;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Sign  <= 1'b0;
      s1Sub   <= 1'b0;
      s1Exp   <= '0;
      s1Big   <= '0;
      s1Small <= '0;
    end else if (strobe.loadAlign) begin
      s1Sign  <= bigOp[WORD_W-1];
      s1Sub   <= opA[WORD_W-1] ^ opB[WORD_W-1];
      s1Exp   <= bigExp;
      s1Big   <= bigExt;
      s1Small <= smallAligned;
    end
  end

  // ---------------- stage 2: combine, normalise, round, pack ----------------
  logic [EXT_W:0]          rawSum;
  logic                    carryOut;
  logic [LZ_W-1:0]         lzCnt;
  logic [EXT_W-1:0]        norm;
  logic signed [EI_W-1:0]  expNorm, expFin, lzExt;
  logic [SIG_W-1:0]        keep;
  logic                    roundUp;
  logic [SIG_W:0]          rounded;
  logic [FRAC_W-1:0]       fracFin;
  logic [WORD_W-1:0]       packed_w;

  always_comb begin
    rawSum   = s1Sub ? ({1'b0, s1Big} - {1'b0, s1Small})
                     : ({1'b0, s1Big} + {1'b0, s1Small});
    carryOut = rawSum[EXT_W];
  end

  always_comb begin
    logic found;
    found = 1'b0;
    lzCnt = '0;
    for (int i = EXT_W - 1; i >= 0; i--) begin
      if (!found) begin
        if (rawSum[i]) found = 1'b1;
        else lzCnt = lzCnt + 1'b1;
      end
    end
  end

  always_comb begin
    lzExt = $signed({{(EI_W-LZ_W){1'b0}}, lzCnt});
    if (carryOut) begin
      norm    = {rawSum[EXT_W:2], rawSum[1] | rawSum[0]};
      expNorm = $signed({2'b00, s1Exp}) + $signed(EI_W'(1));
    end else begin
      norm    = rawSum[EXT_W-1:0] << lzCnt;
      expNorm = $signed({2'b00, s1Exp}) - lzExt;
    end
    keep    = norm[EXT_W-1:3];
    roundUp = norm[2] & (norm[1] | norm[0] | keep[0]);
    rounded = {1'b0, keep} + {{SIG_W{1'b0}}, roundUp};
    if (rounded[SIG_W]) begin
      expFin  = expNorm + $signed(EI_W'(1));
      fracFin = rounded[SIG_W-1:1];
    end else begin
      expFin  = expNorm;
      fracFin = rounded[FRAC_W-1:0];
    end
  end

  always_comb begin
    if (rawSum == '0 || expFin < $signed(EI_W'(1))) begin
      packed_w = '0;
    end else if (expFin > $signed(EI_W'(EXP_MAX))) begin
      packed_w = {s1Sign, EXP_W'(EXP_MAX), {FRAC_W{1'b1}}};
    end else begin
      packed_w = {s1Sign, expFin[EXP_W-1:0], fracFin};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sumOut <= '0;
    else if (strobe.loadResult) sumOut <= packed_w;
  end
endmodule

// File: rtl/minifloat_adder.sv
module minifloat_adder
  import mfa_pkg::*;
#(
  parameter int EXP_W = 5,
  parameter int FRAC_W = 3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  inValid,
  input  logic [EXP_W+FRAC_W:0] opA,
  input  logic [EXP_W+FRAC_W:0] opB,
  output logic                  outValid,
  output logic [EXP_W+FRAC_W:0] outSum
);
  stageStrobe_t strobe;

  mfa_ctrl uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .strobe  (strobe),
    .outValid(outValid)
  );

  mfa_datapath #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) uData (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobe),
    .opA   (opA),
    .opB   (opB),
    .sumOut(outSum)
  );
endmodule

// File: rtl/mfa_checker.sv
module mfa_checker #(
  parameter int EXP_W = 5,
  parameter int FRAC_W = 3
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  inValid,
  input logic                  outValid,
  input logic [EXP_W+FRAC_W:0] outSum
);
  localparam int WORD_W = 1 + EXP_W + FRAC_W;

  logic [1:0] sinceRst;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sinceRst <= '0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
  end

  // R1: result strobe trails the input strobe by two edges
  a_r1_valid_latency: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= 2'd2) |-> (outValid == $past(inValid, 2)));

  // R2: outputs quiet right after reset
  a_r2_reset_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 2'd0) |-> (!outValid && outSum == '0));

  // R8: zero magnitude is always positive
  a_r8_zero_positive: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outSum[WORD_W-2:0] == '0) |-> !outSum[WORD_W-1]);

  // R9: exponent field never reaches all ones
  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outSum[WORD_W-2:FRAC_W] != {EXP_W{1'b1}}));

  // R3: exponent field 0 only appears as the clean zero word
  a_r3_zero_clean: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outSum[WORD_W-2:FRAC_W] == '0) |-> (outSum[FRAC_W-1:0] == '0));
endmodule

bind minifloat_adder mfa_checker #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) uChk (
  .clk     (clk),
  .rstN    (rstN),
  .inValid (inValid),
  .outValid(outValid),
  .outSum  (outSum)
);

// File: tb/minifloat_adder_test.sv
module minifloat_adder_test;
  localparam int CLK_PERIOD = 10;
  localparam int EW = 5;
  localparam int FW = 3;
  localparam int WW = 1 + EW + FW;
  localparam int EMAX = (1 << EW) - 2;
  localparam int WATCHDOG = 20000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [WW-1:0] opA = '0, opB = '0;
  logic outValid;
  logic [WW-1:0] outSum;

  int checkCnt = 0, failCnt = 0;
  bit done = 1'b0;

  logic mV1 = 1'b0, mV2 = 1'b0;
  logic [WW-1:0] mD1 = '0, mD2 = '0;
  string mT1 = "", mT2 = "";

  always #(CLK_PERIOD/2) clk = ~clk;

  minifloat_adder uut (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .opA(opA), .opB(opB), .outValid(outValid), .outSum(outSum)
  );

  function automatic logic [WW-1:0] enc(input bit s, input int e, input int f);
    return {s, EW'(e), FW'(f)};
  endfunction

  function automatic longint valueOf(input logic [WW-1:0] w);
    longint m;
    int e;
    e = int'(w[WW-2:FW]);
    if (e == 0) return 0;
    m = longint'({1'b1, w[FW-1:0]}) <<< (e - 1);
    return w[WW-1] ? -m : m;
  endfunction

  function automatic logic [WW-1:0] refAdd(input logic [WW-1:0] a, input logic [WW-1:0] b);
    longint s, mag, keepV, rem, half;
    int p, e, sh;
    bit neg;
    s = valueOf(a) + valueOf(b);
    if (s == 0) return '0;
    neg = s < 0;
    mag = neg ? -s : s;
    p = 0;
    for (int i = 0; i < 62; i++) if ((mag >> i) & 1) p = i;
    if (p <= FW) begin
      keepV = mag << (FW - p);
    end else begin
      sh = p - FW;
      keepV = mag >> sh;
      rem = mag & ((longint'(1) << sh) - 1);
      half = longint'(1) << (sh - 1);
      if (rem > half || (rem == half && keepV[0])) keepV = keepV + 1;
      if (keepV == (longint'(1) << (FW + 1))) begin
        keepV = keepV >> 1;
        p = p + 1;
      end
    end
    e = p - FW + 1;
    if (e < 1) return '0;
    if (e > EMAX) return {neg, EW'(EMAX), {FW{1'b1}}};
    return {neg, EW'(e), FW'(keepV)};
  endfunction

  task automatic check(input string tag, input logic [WW-1:0] act, input logic [WW-1:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [WW-1:0] a, input logic [WW-1:0] b, input string tag);
    inValid = v;
    opA = a;
    opB = b;
    @(posedge clk);
    #1;
    mV2 = mV1; mD2 = mD1; mT2 = mT1;
    mV1 = v; mD1 = refAdd(a, b); mT1 = tag;
    check("R1 valid", WW'(outValid), WW'(mV2));
    if (mV2) check(mT2, outSum, mD2);
  endtask

  task automatic op(input logic [WW-1:0] a, input logic [WW-1:0] b, input string tag);
    step(1'b1, a, b, tag);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checkCnt++;
      failCnt++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R2 reset valid", WW'(outValid), '0);
    check("R2 reset sum", outSum, '0);
    rstN = 1'b1;
    step(1'b0, '0, '0, "R2 idle");
    check("R2 after release", outSum, '0);

    // R11 zero operand passes the other through
    op(enc(0, 0, 0), enc(1, 20, 5), "R11 zero+x");
    op(enc(0, 9, 6), enc(1, 0, 0), "R11 x+zero");
    // R3 layout, fraction ignored under zero exponent
    op(enc(0, 15, 0), enc(0, 15, 0), "R3 one+one");
    op(enc(0, 0, 5), enc(0, 18, 3), "R3 zero field");
    step(1'b0, '0, '0, "R1 gap");
    // R4 general rounding
    op(enc(1, 23, 2), enc(0, 14, 1), "R4 large minus small");
    op(enc(0, 15, 7), enc(0, 15, 7), "R4 carry out");
    op(enc(0, 20, 1), enc(1, 20, 0), "R4 cancellation");
    // R5 sign of larger magnitude
    op(enc(1, 16, 0), enc(0, 15, 4), "R5 neg larger on A");
    op(enc(0, 15, 4), enc(1, 16, 0), "R5 neg larger on B");
    step(1'b0, '0, '0, "R1 gap");
    step(1'b0, '0, '0, "R1 gap");
    // R6 ties
    op(enc(0, 15, 0), enc(0, 11, 0), "R6 tie keep even");
    op(enc(0, 15, 1), enc(0, 11, 0), "R6 tie round to even");
    // R7 sticky
    op(enc(0, 15, 0), enc(0, 11, 1), "R7 sticky breaks tie");
    op(enc(0, 15, 0), enc(0, 1, 7), "R7 wide gap add");
    op(enc(0, 15, 0), enc(1, 2, 7), "R7 wide gap sub");
    op(enc(0, 15, 1), enc(1, 3, 0), "R7 wide gap sub odd");
    // R8 exact zero
    op(enc(0, 18, 5), enc(1, 18, 5), "R8 x-x");
    op(enc(1, 18, 5), enc(0, 18, 5), "R8 -x+x");
    op(enc(1, 0, 0), enc(1, 0, 0), "R8 negzero sum");
    // R9 saturation
    op(enc(0, 30, 7), enc(0, 30, 7), "R9 pos overflow");
    op(enc(1, 30, 7), enc(1, 30, 0), "R9 neg overflow");
    op(enc(0, 30, 7), enc(0, 26, 0), "R9 rounding overflow");
    // R10 underflow
    op(enc(0, 1, 1), enc(1, 1, 0), "R10 flush");

    for (int n = 0; n < 600; n++) begin
      int ea, eb, d;
      ea = 1 + int'($urandom_range(29));
      d = int'($urandom_range(8)) - 4;
      eb = ((n % 4) == 0) ? 1 + int'($urandom_range(29)) : ea + d;
      if (eb < 1) eb = 1;
      if (eb > 30) eb = 30;
      if ((n % 37) == 0) eb = 0;
      step(($urandom_range(3) != 0),
           enc(1'($urandom_range(1)), ea, int'($urandom_range(7))),
           enc(1'($urandom_range(1)), eb, int'($urandom_range(7))),
           "R4 random");
    end
    step(1'b0, '0, '0, "R1 drain");
    step(1'b0, '0, '0, "R1 drain");

    done = 1'b1;
    summary();
    $finish;
  end
endmodule